// File: doc/BRIEF.md
# Bytecode-to-Microcode Translation Stage

This block is the front stage of a four-stage stack-machine pipeline (translate, microcode fetch, decode, execute). It reads stack-machine bytecodes from an external memory with one cycle of read latency. It turns each opcode into the start address of a native microcode segment. A segment may be one native instruction long or several. The stage presents that start address to the microcode fetch stage and holds it until that stage reports the last instruction of the segment. Only then is the next bytecode fetched. Bytecodes of varying complexity therefore become runs of single-cycle native instructions whose length is known in advance.

Opcodes are mapped through an opcode-indexed jump table. The table is written through a small write port. Each entry carries a valid bit, and an opcode without a valid entry maps to a fixed trap segment. While a segment runs, the microcode stage can pull immediate operand bytes one at a time. Each pull moves the bytecode address past the consumed byte. A branch load from the execute stage discards whatever the stage has fetched and restarts fetching at the target address.

Top module: `bc_xlate_stage`

## Requirements
- R1: While `rst` is high, `seg_valid` and `opnd_valid` are low and `bc_addr` is 0. Two clock cycles after `rst` falls, `seg_valid` is high with the segment for the byte at address 0.
- R2: The memory returns in `bc_rdata` the byte at the `bc_addr` value of the previous cycle. For an opcode with a valid table entry, `seg_addr` equals that entry's microcode address. Once the segment is presented, `bc_addr` points one byte past the opcode.
- R3: An opcode whose table entry is not valid yields `seg_addr` equal to the trap address (all ones by default).
- R4: `seg_valid` stays high and `seg_addr` stays unchanged until `seg_done` is sampled high. In the next cycle `seg_valid` is low, and in the cycle after that the following segment is presented.
- R5: `opnd_req` sampled high while a segment is presented causes `opnd_valid` to be high in the next cycle, with `opnd_byte` equal to the byte at `bc_addr`. `bc_addr` then advances by exactly one.
- R6: When `seg_done` and `opnd_req` are sampled high together, `seg_done` wins. No operand byte is delivered and `bc_addr` does not advance.
- R7: `br_load` sampled high, in any state, makes `seg_valid` low and `bc_addr` equal to `br_target` in the next cycle. Any opcode already fetched is discarded. The segment for the target opcode is presented three cycles after the load.
- R8: A table write with `tbl_vld` high installs `tbl_uaddr` for opcode `tbl_op`. A write with `tbl_vld` low makes that opcode trap. Reset invalidates every entry.
- R9: Apart from a branch load, `bc_addr` either holds or advances by exactly one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bc_addr | output | PC_W | Bytecode memory read address (program counter) |
| bc_rdata | input | 8 | Byte read from the address of the previous cycle |
| tbl_we | input | 1 | Jump table write strobe |
| tbl_op | input | 8 | Opcode whose entry is written |
| tbl_vld | input | 1 | Valid bit written to the entry |
| tbl_uaddr | input | 10 | Microcode start address written to the entry |
| seg_done | input | 1 | Microcode stage is issuing the last instruction of the segment |
| opnd_req | input | 1 | Microcode stage asks for the next operand byte |
| br_load | input | 1 | Execute stage loads a branch target |
| br_target | input | PC_W | Branch target bytecode address |
| seg_valid | output | 1 | A segment start address is presented |
| seg_addr | output | 10 | Microcode segment start address |
| opnd_valid | output | 1 | Operand byte is valid this cycle |
| opnd_byte | output | 8 | Operand byte |

## Verification
The hardest case to reach is a branch load that arrives in the single cycle in which an opcode has already been read from memory but not yet translated. Only then does the flush have something to discard. The bench ends a segment with `seg_done` and drives `br_load` at the very next cycle boundary. It places a trapping opcode at the byte that would otherwise have been translated, so a missed flush shows up as the trap address instead of the target's segment. The simultaneous `seg_done`/`opnd_req` case is reached the same way. The byte after the opcode is itself a valid opcode, so an operand wrongly consumed shifts the next segment address.

// File: rtl/bcx_pkg.sv
package bcx_pkg;

    localparam int OPC_W   = 8;
    localparam int UA_W    = 10;
    localparam int NUM_OPS = 1 << OPC_W;
    localparam logic [UA_W-1:0] TRAP_UA = '1;

    typedef enum logic [1:0] {
        ST_ISSUE,
        ST_OPCODE,
        ST_RUN,
        ST_OPND
    } seq_st_t;

    typedef struct packed {
        logic            vld;
        logic [UA_W-1:0] ua;
    } jt_ent_t;

    function automatic logic seg_active(seq_st_t s);
        return (s == ST_RUN) || (s == ST_OPND);
    endfunction

endpackage

// File: rtl/bcx_jump_table.sv
module bcx_jump_table
    import bcx_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [OPC_W-1:0] wr_op,
    input  logic            wr_vld,
    input  logic [UA_W-1:0] wr_ua,
    input  logic [OPC_W-1:0] rd_op,
    output logic [UA_W-1:0] rd_ua
);

    jt_ent_t ents [NUM_OPS];
    jt_ent_t sel;

    for (genvar i = 0; i < NUM_OPS; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                ents[i].vld <= 1'b0;
            end else if (wr_en && wr_op == OPC_W'(i)) begin
                ents[i].vld <= wr_vld;
                ents[i].ua  <= wr_ua;
            end
        end
    end

    always_comb begin
        sel   = ents[rd_op];
        rd_ua = sel.vld ? sel.ua : TRAP_UA;
    end

endmodule

// File: rtl/bcx_pc_reg.sv
module bcx_pc_reg #(
    parameter int PC_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [PC_W-1:0] load_val,
    input  logic            inc,
    output logic [PC_W-1:0] pc
);

    always_ff @(posedge clk) begin
        if (rst)       pc <= '0;
        else if (load) pc <= load_val;
        else if (inc)  pc <= pc + PC_W'(1);
    end

    // R9
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> (pc == $past(pc)) || (pc == $past(pc) + PC_W'(1)));

    // R7
    pc_load_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> pc == $past(load_val));

endmodule

// File: rtl/bcx_seq_ctrl.sv
module bcx_seq_ctrl
    import bcx_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            seg_done,
    input  logic            opnd_req,
    input  logic            br_load,
    input  logic [UA_W-1:0] lookup_ua,
    output seq_st_t         state,
    output logic [UA_W-1:0] seg_ua,
    output logic            pc_inc
);

    assign pc_inc = !br_load && (state == ST_OPCODE || state == ST_OPND);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_ISSUE;
            seg_ua <= '0;
        end else if (br_load) begin
            state <= ST_ISSUE;
        end else begin
            unique case (state)
                ST_ISSUE:  state <= ST_OPCODE;
                ST_OPCODE: begin
                    seg_ua <= lookup_ua;
                    state  <= ST_RUN;
                end
                ST_RUN: begin
                    if (seg_done)      state <= ST_OPCODE;
                    else if (opnd_req) state <= ST_OPND;
                end
                ST_OPND:   state <= ST_RUN;
                default:   state <= ST_ISSUE;
            endcase
        end
    end

    // R7
    br_flush_chk: assert property (@(posedge clk) disable iff (rst)
        br_load |=> state == ST_ISSUE);

    // R4
    seg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        seg_active(state) && !seg_done && !br_load |=> seg_active(state) && $stable(seg_ua));

    // R6
    done_wins_chk: assert property (@(posedge clk) disable iff (rst)
        state == ST_RUN && seg_done && !br_load |=> state == ST_OPCODE);

endmodule

// File: rtl/bc_xlate_stage.sv
module bc_xlate_stage
    import bcx_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    output logic [PC_W-1:0]  bc_addr,
    input  logic [7:0]       bc_rdata,
    input  logic             tbl_we,
    input  logic [7:0]       tbl_op,
    input  logic             tbl_vld,
    input  logic [9:0]       tbl_uaddr,
    input  logic             seg_done,
    input  logic             opnd_req,
    input  logic             br_load,
    input  logic [PC_W-1:0]  br_target,
    output logic             seg_valid,
    output logic [9:0]       seg_addr,
    output logic             opnd_valid,
    output logic [7:0]       opnd_byte
);

    seq_st_t         state;
    logic [UA_W-1:0] lookup_ua;
    logic [UA_W-1:0] seg_ua;
    logic            pc_inc;

    bcx_jump_table u_tbl (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (tbl_we),
        .wr_op  (tbl_op),
        .wr_vld (tbl_vld),
        .wr_ua  (tbl_uaddr),
        .rd_op  (bc_rdata),
        .rd_ua  (lookup_ua)
    );

    bcx_seq_ctrl u_seq (
        .clk       (clk),
        .rst       (rst),
        .seg_done  (seg_done),
        .opnd_req  (opnd_req),
        .br_load   (br_load),
        .lookup_ua (lookup_ua),
        .state     (state),
        .seg_ua    (seg_ua),
        .pc_inc    (pc_inc)
    );

    bcx_pc_reg #(.PC_W(PC_W)) u_pc (
        .clk      (clk),
        .rst      (rst),
        .load     (br_load),
        .load_val (br_target),
        .inc      (pc_inc),
        .pc       (bc_addr)
    );

    assign seg_valid  = seg_active(state);
    assign seg_addr   = seg_ua;
    assign opnd_valid = (state == ST_OPND);
    assign opnd_byte  = bc_rdata;

    // R5
    opnd_adv_chk: assert property (@(posedge clk) disable iff (rst)
        opnd_valid && !br_load |=> bc_addr == $past(bc_addr) + PC_W'(1));

    // R4
    done_drop_chk: assert property (@(posedge clk) disable iff (rst)
        seg_valid && !opnd_valid && seg_done && !br_load |=> !seg_valid && !opnd_valid);

endmodule

// File: tb/bc_xlate_stage_tb.sv
module bc_xlate_stage_tb;

    localparam int PC_W = 16;
    localparam logic [9:0] TRAP = 10'h3FF;
    localparam int NV = 8;
    // {opcode, operand count}
    localparam logic [15:0] VEC [NV] = '{
        16'h0200, 16'h0401, 16'h8100, 16'h7E02,
        16'h0300, 16'h0000, 16'hFF01, 16'h4000
    };

    logic clk = 1'b0;
    logic rst;
    logic [PC_W-1:0] bc_addr;
    logic [7:0] bc_rdata;
    logic tbl_we, tbl_vld;
    logic [7:0] tbl_op;
    logic [9:0] tbl_uaddr;
    logic seg_done, opnd_req, br_load;
    logic [PC_W-1:0] br_target;
    logic seg_valid, opnd_valid;
    logic [9:0] seg_addr;
    logic [7:0] opnd_byte;

    logic [7:0] mem [2048];
    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    always_ff @(posedge clk) bc_rdata <= mem[bc_addr[10:0]];

    bc_xlate_stage #(.PC_W(PC_W)) u_dut (
        .clk(clk), .rst(rst), .bc_addr(bc_addr), .bc_rdata(bc_rdata),
        .tbl_we(tbl_we), .tbl_op(tbl_op), .tbl_vld(tbl_vld), .tbl_uaddr(tbl_uaddr),
        .seg_done(seg_done), .opnd_req(opnd_req), .br_load(br_load),
        .br_target(br_target), .seg_valid(seg_valid), .seg_addr(seg_addr),
        .opnd_valid(opnd_valid), .opnd_byte(opnd_byte)
    );

    // table policy chosen by the bench: even opcodes below 0x80 map to {op,2'b01}
    function automatic logic [9:0] exp_ua(logic [7:0] op);
        return (op < 8'h80 && !op[0]) ? {op, 2'b01} : TRAP;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_branch(logic [PC_W-1:0] tgt);
        br_load = 1'b1; br_target = tgt;
        @(negedge clk);
        chk("R7 seg_valid after load", 32'(seg_valid), 0);
        chk("R7 bc_addr after load", 32'(bc_addr), 32'(tgt));
        br_load = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 20000);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int pos;
        for (int a = 0; a < 2048; a++) mem[a] = 8'h00;
        pos = 0;
        for (int i = 0; i < NV; i++) begin
            mem[pos] = VEC[i][15:8];
            for (int k = 0; k < int'(VEC[i][7:0]); k++)
                mem[pos + 1 + k] = VEC[i][15:8] ^ (8'h5A + 8'(k));
            pos += 1 + int'(VEC[i][7:0]);
        end
        mem[16'h100] = 8'h22; mem[16'h101] = 8'h11;
        mem[16'h200] = 8'h30;
        mem[16'h300] = 8'h06; mem[16'h301] = 8'h08;
        mem[16'h400] = 8'h40;

        rst = 1'b1; tbl_we = 0; tbl_op = 0; tbl_vld = 0; tbl_uaddr = 0;
        seg_done = 0; opnd_req = 0; br_load = 0; br_target = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 seg_valid in reset", 32'(seg_valid), 0);
        chk("R1 opnd_valid in reset", 32'(opnd_valid), 0);
        chk("R1 bc_addr in reset", 32'(bc_addr), 0);
        rst = 1'b0;

        // R8 install entries through the write port
        for (int op = 0; op < 128; op += 2) begin
            tbl_we = 1; tbl_op = 8'(op); tbl_vld = 1; tbl_uaddr = {8'(op), 2'b01};
            @(negedge clk);
        end
        tbl_we = 0;

        // restart at 0 and walk the vector table
        do_branch('0);
        pos = 0;
        for (int i = 0; i < NV; i++) begin
            logic [7:0] op;
            op = VEC[i][15:8];
            chk("R4 segment presented", 32'(seg_valid), 1);
            chk((exp_ua(op) == TRAP) ? "R3 trap address" : "R2 segment address",
                32'(seg_addr), 32'(exp_ua(op)));
            chk("R2 pc past opcode", 32'(bc_addr), 32'(pos + 1));
            for (int k = 0; k < int'(VEC[i][7:0]); k++) begin
                opnd_req = 1;
                @(negedge clk);
                chk("R5 opnd_valid", 32'(opnd_valid), 1);
                chk("R5 opnd_byte", 32'(opnd_byte), 32'(op ^ (8'h5A + 8'(k))));
                opnd_req = 0;
                @(negedge clk);
                chk("R5 pc past operand", 32'(bc_addr), 32'(pos + 2 + k));
                chk("R4 seg_addr held", 32'(seg_addr), 32'(exp_ua(op)));
            end
            seg_done = 1;
            @(negedge clk);
            chk("R4 seg_valid low after done", 32'(seg_valid), 0);
            seg_done = 0;
            @(negedge clk);
            pos += 1 + int'(VEC[i][7:0]);
        end

        // R7 branch while a segment runs
        do_branch(16'h100);
        chk("R7 target segment", 32'(seg_addr), 32'(exp_ua(8'h22)));
        chk("R7 target valid", 32'(seg_valid), 1);
        chk("R7 pc after target", 32'(bc_addr), 32'h101);

        // R7 branch in the cycle an opcode (trapping 0x11) was already fetched
        seg_done = 1;
        @(negedge clk);
        seg_done = 0;
        do_branch(16'h200);
        chk("R7 flushed fetch", 32'(seg_addr), 32'(exp_ua(8'h30)));
        chk("R7 flushed fetch valid", 32'(seg_valid), 1);

        // R6 done and operand request together
        do_branch(16'h300);
        chk("R6 first segment", 32'(seg_addr), 32'(exp_ua(8'h06)));
        seg_done = 1; opnd_req = 1;
        @(negedge clk);
        chk("R6 no operand", 32'(opnd_valid), 0);
        chk("R6 seg_valid low", 32'(seg_valid), 0);
        seg_done = 0; opnd_req = 0;
        @(negedge clk);
        chk("R6 next segment", 32'(seg_addr), 32'(exp_ua(8'h08)));
        chk("R6 pc not skipped", 32'(bc_addr), 32'h302);

        // R8 clearing an entry makes the opcode trap
        tbl_we = 1; tbl_op = 8'h40; tbl_vld = 0; tbl_uaddr = 10'h055;
        @(negedge clk);
        tbl_we = 0;
        do_branch(16'h400);
        chk("R8 cleared entry traps", 32'(seg_addr), 32'(TRAP));

        // R1 latency after reset, R8 reset invalidates table
        rst = 1;
        @(negedge clk);
        chk("R1 seg_valid in reset", 32'(seg_valid), 0);
        chk("R1 bc_addr in reset", 32'(bc_addr), 0);
        rst = 0;
        @(negedge clk);
        chk("R1 not yet valid", 32'(seg_valid), 0);
        @(negedge clk);
        chk("R1 valid two cycles after reset", 32'(seg_valid), 1);
        chk("R8 reset clears table", 32'(seg_addr), 32'(TRAP));

        finish_run();
    end

endmodule